// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire stereo audio stream into parallel samples. The wires are a bit clock, a frame clock that marks the channel, and a data line carrying two's-complement words MSB first. All three are brought into the system clock domain through synchronizer chains. Each data bit is taken at a rising edge of the bit clock, and a change of frame-clock level marks the end of one channel slot and the start of the next.

A static 2-bit selector picks one of four framings. Two of them are MSB-first, with a one-bit delay or with no delay. The other two are right-justified, with a 24-bit or a 16-bit word ending on the last bit before the frame-clock change. Every word comes out as 24 bits: short MSB-first words are padded with zero LSBs, and 16-bit right-justified words are sign-extended. A left/right pair is presented together with a one-cycle valid pulse after the right word has finished.

Top module: `serial_audio_rx`

## Requirements
- R1: With selector 00 the left channel is the slot in which the frame clock is low. The MSB arrives on the second bit-clock rising edge of the slot, and up to 24 bits follow.
- R2: With selector 01 the left channel is the slot in which the frame clock is high. The MSB arrives on the first bit-clock rising edge of the slot, and up to 24 bits follow.
- R3: With selector 10 (frame clock high = left) the word is the last 24 bits of the slot, ending on the final rising edge before the frame-clock change. Earlier bits of the slot are ignored.
- R4: With selector 11 (frame clock high = left) the word is the last 16 bits of the slot, and bit 15 is copied into output bits 23 to 16. Earlier bits of the slot are ignored.
- R5: In the MSB-first formats, a slot carrying fewer than 24 data bits yields a word whose unfilled low bits are zero. Slot bits after the 24th data bit are ignored.
- R6: The valid output is high for exactly one clock cycle per stereo frame. The left and right outputs change only in that cycle and otherwise hold their values.
- R7: A slot that began before the first frame-clock change seen after reset is discarded. A right slot not preceded by a complete left slot produces no valid pulse.
- R8: During and after reset, both sample outputs are zero and valid is low.
- R9: The valid pulse appears exactly SYNC_STAGES+3 clock cycles after the bit-clock rising edge that first shows the frame-clock change ending the right slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Framing selector (00, 01, 10, 11 as in R1 to R4); static outside reset |
| bit_clk | input | 1 | Serial bit clock, sampled on clk |
| frame_clk | input | 1 | Frame clock selecting the channel |
| ser_data | input | 1 | Serial data, MSB first, two's complement |
| left_o | output | 24 | Left sample of the last completed frame |
| right_o | output | 24 | Right sample of the last completed frame |
| frame_valid_o | output | 1 | One-cycle pulse when a new left/right pair is presented |

## Verification
If the bit counter is off by one, every word comes out shifted by one bit position. This shows at the first valid pulse after the fault, at most one frame later. If the right-justified shift register has the wrong length or sign source, the upper bits of the right-justified words are wrong at the next pulse. If the left-pending flag or the slot-start flag is corrupted, valid pulses are missing or extra, or a discarded partial slot shows up as a sample. Such errors appear within the first two frames after reset. An extra or missing pipeline stage changes the fixed pulse latency and shows at every pulse.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      FMT_DELAYED  = 2'b00,
      FMT_ALIGNED  = 2'b01,
      FMT_RJ_LONG  = 2'b10,
      FMT_RJ_SHORT = 2'b11
   } sar_fmt_e;

   function automatic logic left_level(input sar_fmt_e f);
      return (f == FMT_DELAYED) ? 1'b0 : 1'b1;
   endfunction

   function automatic logic is_msb_first(input sar_fmt_e f);
      return (f == FMT_DELAYED) || (f == FMT_ALIGNED);
   endfunction

endpackage

// File: rtl/sar_sync_chain.sv
module sar_sync_chain #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stage_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("sar_sync_chain: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= RESET_VAL;
            else        stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RESET_VAL;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sar_link_front.sv
module sar_link_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_clk,
   input  logic frame_clk,
   input  logic ser_data,
   output logic tick_o,
   output logic lvl_o,
   output logic bit_o
);
   localparam int NUM_LINES = 3;

   logic [NUM_LINES-1:0] raw_in;
   logic [NUM_LINES-1:0] synced;
   logic                 bclk_prev_q;

   assign raw_in = {ser_data, frame_clk, bit_clk};

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      sar_sync_chain #(
         .STAGES    (SYNC_STAGES),
         .RESET_VAL (1'b0)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw_in[i]),
         .q     (synced[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_prev_q <= 1'b0;
         tick_o      <= 1'b0;
         lvl_o       <= 1'b0;
         bit_o       <= 1'b0;
      end else begin
         bclk_prev_q <= synced[0];
         tick_o      <= synced[0] & ~bclk_prev_q;
         lvl_o       <= synced[1];
         bit_o       <= synced[2];
      end
   end

   // R9: a rising-edge tick is isolated, so each bit is taken once
   a_r9_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/sar_slot_assembler.sv
module sar_slot_assembler
   import sar_pkg::*;
#(
   parameter int WORD_W  = 24,
   parameter int SHORT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sar_fmt_e          fmt,
   input  logic              tick_i,
   input  logic              lvl_i,
   input  logic              bit_i,
   output logic              done_o,
   output logic              done_left_o,
   output logic              done_ok_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] K_WORD  = CNT_W'(WORD_W);
   localparam int EXT_W = WORD_W - SHORT_W;

   if (SHORT_W >= WORD_W) begin : g_bad_short
      $error("sar_slot_assembler: SHORT_W must be below WORD_W");
   end
   if (WORD_W < 8) begin : g_bad_word
      $error("sar_slot_assembler: WORD_W must be at least 8");
   end

   logic              have_prev_q;
   logic              prev_lvl_q;
   logic              in_slot_q;
   logic [CNT_W-1:0]  kcnt_q;
   logic [WORD_W-1:0] msb_word_q;
   logic [WORD_W-1:0] shreg_q;

   logic              boundary;
   logic [CNT_W-1:0]  k_now;
   logic              wr_en;
   logic [CNT_W-1:0]  wr_pos;
   logic [WORD_W-1:0] msb_next;
   logic [WORD_W-1:0] rj_word;
   logic [WORD_W-1:0] slot_word;

   assign boundary = tick_i && have_prev_q && (lvl_i != prev_lvl_q);
   assign k_now    = boundary ? '0 : kcnt_q;

   always_comb begin
      wr_en  = 1'b0;
      wr_pos = '0;
      unique case (fmt)
         FMT_DELAYED: begin
            wr_en  = (k_now != '0) && (k_now <= K_WORD);
            wr_pos = K_WORD - k_now;
         end
         FMT_ALIGNED: begin
            wr_en  = (k_now < K_WORD);
            wr_pos = K_WORD - CNT_W'(1) - k_now;
         end
         default: begin
            wr_en  = 1'b0;
            wr_pos = '0;
         end
      endcase
   end

   always_comb begin
      msb_next = boundary ? '0 : msb_word_q;
      if (wr_en) msb_next[wr_pos] = bit_i;
   end

   always_comb begin
      if (fmt == FMT_RJ_SHORT)
         rj_word = {{EXT_W{shreg_q[SHORT_W-1]}}, shreg_q[SHORT_W-1:0]};
      else
         rj_word = shreg_q;
   end

   assign slot_word = is_msb_first(fmt) ? msb_word_q : rj_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev_q <= 1'b0;
         prev_lvl_q  <= 1'b0;
         in_slot_q   <= 1'b0;
         kcnt_q      <= '0;
         msb_word_q  <= '0;
         shreg_q     <= '0;
         done_o      <= 1'b0;
         done_left_o <= 1'b0;
         done_ok_o   <= 1'b0;
         word_o      <= '0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            have_prev_q <= 1'b1;
            prev_lvl_q  <= lvl_i;
            shreg_q     <= {shreg_q[WORD_W-2:0], bit_i};
            msb_word_q  <= msb_next;
            if (boundary) begin
               done_o      <= 1'b1;
               done_left_o <= (prev_lvl_q == left_level(fmt));
               done_ok_o   <= in_slot_q;
               word_o      <= slot_word;
               in_slot_q   <= 1'b1;
               kcnt_q      <= CNT_W'(1);
            end else if (kcnt_q != CNT_MAX) begin
               kcnt_q <= kcnt_q + CNT_W'(1);
            end
         end
      end
   end

   // R9: a finished slot is reported one cycle after the tick that ended it
   a_r9_done_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(tick_i));

   // R7: the first reported slot after reset is never marked complete
   a_r7_first_slot_partial: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !$past(in_slot_q)) |-> !done_ok_o);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int SHORT_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fmt_sel,
   input  logic              bit_clk,
   input  logic              frame_clk,
   input  logic              ser_data,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              frame_valid_o
);
   sar_fmt_e          fmt;
   logic              tick;
   logic              lvl;
   logic              sbit;
   logic              done;
   logic              done_left;
   logic              done_ok;
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] left_hold_q;
   logic              left_pending_q;

   assign fmt = sar_fmt_e'(fmt_sel);

   sar_link_front #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_clk   (bit_clk),
      .frame_clk (frame_clk),
      .ser_data  (ser_data),
      .tick_o    (tick),
      .lvl_o     (lvl),
      .bit_o     (sbit)
   );

   sar_slot_assembler #(
      .WORD_W  (WORD_W),
      .SHORT_W (SHORT_W)
   ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .fmt         (fmt),
      .tick_i      (tick),
      .lvl_i       (lvl),
      .bit_i       (sbit),
      .done_o      (done),
      .done_left_o (done_left),
      .done_ok_o   (done_ok),
      .word_o      (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold_q    <= '0;
         left_pending_q <= 1'b0;
         left_o         <= '0;
         right_o        <= '0;
         frame_valid_o  <= 1'b0;
      end else begin
         frame_valid_o <= 1'b0;
         if (done) begin
            if (!done_ok) begin
               left_pending_q <= 1'b0;
            end else if (done_left) begin
               left_hold_q    <= word;
               left_pending_q <= 1'b1;
            end else begin
               left_pending_q <= 1'b0;
               if (left_pending_q) begin
                  left_o        <= left_hold_q;
                  right_o       <= word;
                  frame_valid_o <= 1'b1;
               end
            end
         end
      end
   end

   // R6: the valid pulse lasts a single cycle
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |=> !frame_valid_o);

   // R6: sample outputs move only together with the valid pulse
   a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(left_o) || !$stable(right_o)) |-> frame_valid_o);

   // R7: a right slot without a pending left never yields a pulse
   a_r7_no_orphan_right: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_left && !left_pending_q) |=> !frame_valid_o);

   // R4: short right-justified words come out sign-extended
   a_r4_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid_o && fmt == FMT_RJ_SHORT) |->
         (right_o[WORD_W-1:SHORT_W] == {(WORD_W-SHORT_W){right_o[SHORT_W-1]}}));
endmodule

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;
   localparam int W    = 24;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    fmt_sel = 2'b00;
   logic          bit_clk = 1'b0;
   logic          frame_clk = 1'b0;
   logic          ser_data = 1'b0;
   logic [W-1:0]  left_o, right_o;
   logic          frame_valid_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int t_edge = 0;
   int cap_n = 0;
   int wide_err = 0;
   int hold_err = 0;
   int lat_bad = 0;
   logic [W-1:0] cap_l [16];
   logic [W-1:0] cap_r [16];
   logic          prev_valid = 1'b0;
   logic [W-1:0] prev_l = '0, prev_r = '0;
   bit            finished = 0;

   serial_audio_rx #(.WORD_W(W), .SHORT_W(16), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bit_clk(bit_clk),
      .frame_clk(frame_clk), .ser_data(ser_data), .left_o(left_o),
      .right_o(right_o), .frame_valid_o(frame_valid_o));

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (frame_valid_o) begin
            if (cap_n < 16) begin
               cap_l[cap_n] = left_o;
               cap_r[cap_n] = right_o;
            end
            cap_n = cap_n + 1;
            if (cyc - t_edge != LAT) lat_bad = lat_bad + 1;
            if (prev_valid) wide_err = wide_err + 1;
         end else if (left_o != prev_l || right_o != prev_r) begin
            hold_err = hold_err + 1;
         end
         prev_valid = frame_valid_o;
         prev_l = left_o;
         prev_r = right_o;
      end
   end

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [W-1:0] pat(input int i);
      case (i % 6)
         0: return 24'hA5C317;
         1: return 24'h3E91B4;
         2: return 24'h800001;
         3: return 24'h7FFFFE;
         4: return 24'h00F0F0;
         default: return 24'hFF8421;
      endcase
   endfunction

   function automatic logic slot_bit(input int f, input logic [W-1:0] w, input int n, input int k);
      case (f)
         0: return (k >= 1 && k <= 24) ? w[24 - k] : 1'b1;
         1: return (k < 24) ? w[23 - k] : 1'b1;
         2: return (k >= n - 24) ? w[23 - (k - (n - 24))] : 1'b1;
         default: return (k >= n - 16) ? w[15 - (k - (n - 16))] : 1'b1;
      endcase
   endfunction

   function automatic logic [W-1:0] exp_word(input int f, input logic [W-1:0] w, input int n);
      int nb;
      logic [W-1:0] mask;
      case (f)
         0, 1: begin
            nb = (f == 0) ? n - 1 : n;
            if (nb > 24) nb = 24;
            mask = (nb >= 24) ? '1 : ~((24'h1 << (24 - nb)) - 24'h1);
            return w & mask;
         end
         2: return w;
         default: return {{8{w[15]}}, w[15:0]};
      endcase
   endfunction

   task automatic send_bit(input logic lv, input logic b, input bit mark);
      @(negedge clk);
      bit_clk = 1'b0; frame_clk = lv; ser_data = b;
      repeat (4) @(negedge clk);
      bit_clk = 1'b1;
      if (mark) t_edge = cyc;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_slot(input int f, input logic lv, input logic [W-1:0] w, input int n, input bit mark_first);
      for (int k = 0; k < n; k++) send_bit(lv, slot_bit(f, w, n, k), mark_first && k == 0);
   endtask

   task automatic do_reset(input logic [1:0] f);
      rst_n = 1'b0; bit_clk = 1'b0; ser_data = 1'b0;
      frame_clk = (f == 2'b00) ? 1'b0 : 1'b1;
      fmt_sel = f;
      repeat (4) @(negedge clk);
      cap_n = 0; wide_err = 0; hold_err = 0; lat_bad = 0;
      prev_valid = 1'b0; prev_l = '0; prev_r = '0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // one stereo stream in a given format and slot length, then check every pair
   task automatic run_stream(input string req, input int f, input int n, input int nfr);
      logic lft;
      do_reset(2'(f));
      lft = (f == 0) ? 1'b0 : 1'b1;
      send_slot(f, lft, pat(5), 3, 0);          // partial slot after reset
      send_slot(f, ~lft, pat(4), n, 0);         // orphan right slot
      for (int i = 0; i < nfr; i++) begin
         send_slot(f, lft, pat(2 * i), n, 1);
         send_slot(f, ~lft, pat(2 * i + 1), n, 0);
      end
      send_slot(f, lft, pat(0), 2, 1);
      repeat (20) @(negedge clk);
      check("R7 pulse count", W'(cap_n), W'(nfr));
      for (int i = 0; i < nfr && i < 16 && i < cap_n; i++) begin
         check({req, " left"},  cap_l[i], exp_word(f, pat(2 * i), n));
         check({req, " right"}, cap_r[i], exp_word(f, pat(2 * i + 1), n));
      end
      check("R6 single-cycle pulse", W'(wide_err), '0);
      check("R6 hold between pulses", W'(hold_err), '0);
      check("R9 pulse latency", W'(lat_bad), '0);
   endtask

   task automatic test_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 left at reset", left_o, '0);
      check("R8 right at reset", right_o, '0);
      check("R8 valid at reset", W'(frame_valid_o), '0);
   endtask

   initial begin
      test_reset();
      run_stream("R1", 0, 32, 3);
      run_stream("R2", 1, 32, 3);
      run_stream("R3", 2, 32, 3);
      run_stream("R4", 3, 32, 4);
      run_stream("R5 short delayed", 0, 20, 2);
      run_stream("R5 short aligned", 1, 16, 2);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule